// File: doc/BRIEF.md
# Compressed-Audio Burst Sync Detector

This block sits behind a digital audio receiver and inspects the 16-bit data words it recovers, one word per subframe. Each word arrives with a valid strobe, and the first word of every frame also carries a frame-start marker. The block looks for the fixed six-word sync pattern that opens a compressed (non-PCM) data burst. When it finds the pattern, it raises a sticky non-PCM flag.

The two words that follow each sync pattern describe the burst. The first gives the burst information and the second gives the burst length. The block captures both into holding registers and pulses an update strobe when the pair is complete. A one-bit select drives either captured word onto a read port.

The flag clears after a long run of frames that contains no new sync pattern. The length of that run is a parameter, with a default of 4096 frames. Each new detection restarts the count.

Top module: `burst_sync_detector`

## Requirements
- R1: The non-PCM flag `nonpcm_o` goes high at the clock edge that accepts the sixth valid word of the sequence 0x0000, 0x0000, 0x0000, 0x0000, 0xF872, 0x4E1F, where the words are consecutive valid words in that order.
- R2: Only words with `word_valid_i` high count toward the sequence, and idle cycles between valid words do not break it. A sequence may begin at any valid word, including inside a longer run of zeros. Fewer than six valid words since reset never produce a detection.
- R3: A frame is one valid word with `frame_start_i` high. A `frame_start_i` seen while `word_valid_i` is low is not a frame. The flag returns low at the edge that accepts the 4096th frame (`TIMEOUT_FRAMES`) after the most recent detection.
- R4: The first two valid words after a detection are captured. `pc_o` takes the first and `pd_o` takes the second. Both update together at the edge that accepts the second word. Before that edge they hold their previous values.
- R5: `upd_o` is high for exactly one cycle, in the cycle after the edge at which `pc_o` and `pd_o` update.
- R6: A detection while the flag is already high keeps the flag high and restarts the frame count from zero.
- R7: `rd_data_o` shows `pc_o` when `rd_sel_i` is 0 and `pd_o` when `rd_sel_i` is 1, with no clock delay.
- R8: While `rst_ni` is low, the flag, the frame count, `pc_o`, `pd_o` and `upd_o` are all zero, and the word history is emptied.
- R9: A sequence whose last word is not 0x4E1F does not raise the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| word_valid_i | input | 1 | The word on word_i is valid this cycle |
| word_i | input | 16 | Recovered audio data word |
| frame_start_i | input | 1 | The word is the first of a frame |
| rd_sel_i | input | 1 | Read select: 0 = burst info, 1 = burst length |
| nonpcm_o | output | 1 | Sticky non-PCM flag |
| pc_o | output | 16 | Captured burst-info word |
| pd_o | output | 16 | Captured burst-length word |
| upd_o | output | 1 | One-cycle pulse on a capture update |
| rd_data_o | output | 16 | Selected captured word |

## Verification
Every registered result is due one edge after the valid word that causes it. The flag rises at the edge that accepts the sixth sync word. The capture registers and the update pulse change at the edge that accepts the second word after the sync. The flag falls at the edge that accepts the 4096th frame word. The read port is combinational and follows the select within the same cycle.

The bench drives each word on the falling edge. It samples 1 ns after the next rising edge, so every check sees exactly the edge that accepted the word. Timeout and restart checks count frame words one by one. They sample just before and just after the boundary word.

// File: rtl/bsd_pkg.sv
package bsd_pkg;
  localparam int WORD_W   = 16;
  localparam int SYNC_LEN = 6;

  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_PC   = 2'd1,
    CAP_PD   = 2'd2
  } cap_state_e;

  // idx 0 is the oldest word of the burst sync pattern
  function automatic logic [WORD_W-1:0] sync_word(input int idx);
    case (idx)
      4:       sync_word = 16'hF872;
      5:       sync_word = 16'h4E1F;
      default: sync_word = '0;
    endcase
  endfunction
endpackage

// File: rtl/bsd_matcher.sv
module bsd_matcher
  import bsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              hit_o
);
  localparam int HIST_N = SYNC_LEN - 1;
  localparam int FILL_W = $clog2(HIST_N + 1);

  logic [WORD_W-1:0] hist_q [HIST_N];
  logic [FILL_W-1:0] fill_q;
  logic [HIST_N-1:0] eq;

  // hist_q[0] is the newest stored word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < HIST_N; i++) hist_q[i] <= '0;
    end else if (vld_i) begin
      hist_q[0] <= word_i;
      for (int i = 1; i < HIST_N; i++) hist_q[i] <= hist_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)
      fill_q <= '0;
    else if (vld_i && fill_q != FILL_W'(HIST_N))
      fill_q <= fill_q + 1'b1;
  end

  for (genvar g = 0; g < HIST_N; g++) begin : g_cmp
    assign eq[g] = (hist_q[g] == sync_word(SYNC_LEN - 2 - g));
  end

  assign hit_o = vld_i && (fill_q == FILL_W'(HIST_N)) && (&eq)
                 && (word_i == sync_word(SYNC_LEN - 1));
endmodule

// File: rtl/bsd_capture.sv
module bsd_capture
  import bsd_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic              hit_i,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] pd_o,
  output logic              upd_o
);
  cap_state_e        st_q, st_d;
  logic [WORD_W-1:0] pc_tmp_q;

  always_comb begin
    st_d = st_q;
    if (hit_i)
      st_d = CAP_PC;
    else if (vld_i) begin
      case (st_q)
        CAP_PC:  st_d = CAP_PD;
        CAP_PD:  st_d = CAP_IDLE;
        default: st_d = CAP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= CAP_IDLE;
      pc_tmp_q <= '0;
      pc_o     <= '0;
      pd_o     <= '0;
      upd_o    <= 1'b0;
    end else begin
      st_q  <= st_d;
      upd_o <= 1'b0;
      if (!hit_i && vld_i) begin
        if (st_q == CAP_PC) pc_tmp_q <= word_i;
        if (st_q == CAP_PD) begin
          pc_o  <= pc_tmp_q;
          pd_o  <= word_i;
          upd_o <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/bsd_frame_timer.sv
module bsd_frame_timer #(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic frame_i,
  output logic flag_o
);
  localparam int CNT_W = (TIMEOUT_FRAMES > 1) ? $clog2(TIMEOUT_FRAMES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_FRAMES - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_o <= 1'b0;
      cnt_q  <= '0;
    end else if (hit_i) begin
      flag_o <= 1'b1;
      cnt_q  <= '0;
    end else if (flag_o && frame_i) begin
      if (cnt_q == LAST) begin
        flag_o <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/burst_sync_detector.sv
module burst_sync_detector #(
  parameter int TIMEOUT_FRAMES = 4096
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        word_valid_i,
  input  logic [15:0] word_i,
  input  logic        frame_start_i,
  input  logic        rd_sel_i,
  output logic        nonpcm_o,
  output logic [15:0] pc_o,
  output logic [15:0] pd_o,
  output logic        upd_o,
  output logic [15:0] rd_data_o
);
  logic hit;
  logic frame_tick;

  assign frame_tick = word_valid_i && frame_start_i;

  bsd_matcher u_match (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (word_valid_i),
    .word_i (word_i),
    .hit_o  (hit)
  );

  bsd_capture u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .vld_i  (word_valid_i),
    .word_i (word_i),
    .hit_i  (hit),
    .pc_o   (pc_o),
    .pd_o   (pd_o),
    .upd_o  (upd_o)
  );

  bsd_frame_timer #(.TIMEOUT_FRAMES(TIMEOUT_FRAMES)) u_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .hit_i   (hit),
    .frame_i (frame_tick),
    .flag_o  (nonpcm_o)
  );

  assign rd_data_o = rd_sel_i ? pd_o : pc_o;
endmodule

// File: rtl/bsd_checker.sv
module bsd_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        word_valid_i,
  input logic [15:0] word_i,
  input logic        frame_start_i,
  input logic        rd_sel_i,
  input logic        nonpcm_o,
  input logic [15:0] pc_o,
  input logic [15:0] pd_o,
  input logic        upd_o,
  input logic [15:0] rd_data_o
);
  a_r1_rise_on_last_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(nonpcm_o) |-> ($past(word_valid_i) && $past(word_i) == 16'h4E1F));

  a_r3_fall_on_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nonpcm_o) |-> $past(word_valid_i && frame_start_i));

  a_r4_hold_without_update: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_o |-> ($stable(pc_o) && $stable(pd_o)));

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |=> !upd_o);

  a_r5_pulse_needs_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_o |-> $past(word_valid_i));

  a_r7_read_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($stable(rd_sel_i) && !upd_o) |-> $stable(rd_data_o));

  a_r8_reset_clear: assert property (@(posedge clk_i)
    !rst_ni |-> (!nonpcm_o && !upd_o && pc_o == '0 && pd_o == '0));
endmodule

bind burst_sync_detector bsd_checker u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .word_valid_i  (word_valid_i),
  .word_i        (word_i),
  .frame_start_i (frame_start_i),
  .rd_sel_i      (rd_sel_i),
  .nonpcm_o      (nonpcm_o),
  .pc_o          (pc_o),
  .pd_o          (pd_o),
  .upd_o         (upd_o),
  .rd_data_o     (rd_data_o)
);

// File: tb/sim_burst_sync_detector.sv
`timescale 1ns/1ps
module sim_burst_sync_detector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vld = 1'b0;
  logic [15:0] word = '0;
  logic        fs = 1'b0;
  logic        sel = 1'b0;
  logic        nonpcm;
  logic [15:0] pc, pd, rdata;
  logic        upd;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  burst_sync_detector u0 (
    .clk_i(clk), .rst_ni(rst_n), .word_valid_i(vld), .word_i(word),
    .frame_start_i(fs), .rd_sel_i(sel), .nonpcm_o(nonpcm),
    .pc_o(pc), .pd_o(pd), .upd_o(upd), .rd_data_o(rdata)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // drive on falling edge, sample 1 ns after the accepting rising edge
  task automatic send(input logic [15:0] w, input logic f);
    @(negedge clk);
    vld = 1'b1; word = w; fs = f;
    @(posedge clk); #1;
    vld = 1'b0; fs = 1'b0;
  endtask

  task automatic idle(input logic [15:0] w, input logic f);
    @(negedge clk);
    vld = 1'b0; word = w; fs = f;
    @(posedge clk); #1;
    fs = 1'b0;
  endtask

  task automatic send_sync();
    for (int i = 0; i < 4; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    send(16'h4E1F, 1'b0);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; vld = 1'b0; fs = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    #1;
    chk(nonpcm == 1'b0, "R8 flag in reset", nonpcm, 0);
    chk(pc == 16'h0 && pd == 16'h0, "R8 regs in reset", {pc, pd}, 0);
    chk(upd == 1'b0, "R8 upd in reset", upd, 0);
    do_reset();
  endtask

  task automatic t_detect_capture();
    for (int i = 0; i < 4; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    chk(nonpcm == 1'b0, "R1 flag before last word", nonpcm, 0);
    send(16'h4E1F, 1'b0);
    chk(nonpcm == 1'b1, "R1 flag on sixth word", nonpcm, 1);
    send(16'h0115, 1'b0);
    chk(pc == 16'h0 && upd == 1'b0, "R4 hold after first word", pc, 0);
    send(16'h2A00, 1'b0);
    chk(pc == 16'h0115, "R4 pc captured", pc, 16'h0115);
    chk(pd == 16'h2A00, "R4 pd captured", pd, 16'h2A00);
    chk(upd == 1'b1, "R5 upd high", upd, 1);
    idle(16'h0, 1'b0);
    chk(upd == 1'b0, "R5 upd one cycle", upd, 0);
    sel = 1'b0; #1;
    chk(rdata == 16'h0115, "R7 read pc", rdata, 16'h0115);
    sel = 1'b1; #1;
    chk(rdata == 16'h2A00, "R7 read pd", rdata, 16'h2A00);
    sel = 1'b0;
    do_reset();
    chk(nonpcm == 1'b0 && pc == 16'h0 && pd == 16'h0, "R8 reset clears", {nonpcm, pc}, 0);
  endtask

  task automatic t_patterns();
    send(16'hF872, 1'b0);
    send(16'h4E1F, 1'b0);
    chk(nonpcm == 1'b0, "R2 short history no hit", nonpcm, 0);
    do_reset();
    for (int i = 0; i < 4; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    send(16'h1234, 1'b0);
    chk(nonpcm == 1'b0, "R9 wrong last word", nonpcm, 0);
    for (int i = 0; i < 7; i++) send(16'h0000, 1'b0);
    send(16'hF872, 1'b0);
    send(16'h4E1F, 1'b0);
    chk(nonpcm == 1'b1, "R2 overlap in zero run", nonpcm, 1);
    do_reset();
    send(16'h0000, 1'b0);
    send(16'h0000, 1'b0);
    idle(16'hF872, 1'b0);
    send(16'h0000, 1'b0);
    send(16'h0000, 1'b0);
    idle(16'h4E1F, 1'b0);
    send(16'hF872, 1'b0);
    chk(nonpcm == 1'b0, "R2 invalid words ignored", nonpcm, 0);
    send(16'h4E1F, 1'b0);
    chk(nonpcm == 1'b1, "R2 hit across idle gaps", nonpcm, 1);
    do_reset();
  endtask

  task automatic t_timeout();
    send_sync();
    for (int i = 0; i < 4095; i++) send(16'h5555, 1'b1);
    chk(nonpcm == 1'b1, "R3 high after 4095 frames", nonpcm, 1);
    for (int i = 0; i < 3; i++) idle(16'h5555, 1'b1);
    chk(nonpcm == 1'b1, "R3 unqualified frame ignored", nonpcm, 1);
    send(16'h5555, 1'b1);
    chk(nonpcm == 1'b0, "R3 low at 4096th frame", nonpcm, 0);
    do_reset();
  endtask

  task automatic t_retrigger();
    send_sync();
    for (int i = 0; i < 3000; i++) send(16'h3333, 1'b1);
    send_sync();
    chk(nonpcm == 1'b1, "R6 flag held on redetect", nonpcm, 1);
    for (int i = 0; i < 4095; i++) send(16'h3333, 1'b1);
    chk(nonpcm == 1'b1, "R6 count restarted", nonpcm, 1);
    send(16'h3333, 1'b1);
    chk(nonpcm == 1'b0, "R6 low 4096 frames after redetect", nonpcm, 0);
    do_reset();
  endtask

  initial begin
    t_reset();
    t_detect_capture();
    t_patterns();
    t_timeout();
    t_retrigger();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule